// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame should be kept or thrown away, based on its 48-bit destination address. It watches a byte-wide receive stream, collects the first six bytes of each frame, and compares them in parallel against a table of programmable station addresses. One clock after the sixth byte it presents a single keep/discard decision. Software loads the table through a simple register write port. The usual arrangement puts the broadcast address in entry 0, the station's own address in entry 1, and multicast groups in the entries after that. When more groups are wanted than the table can hold, software clears the control word and turns on the accept-all mode instead.

The table has `NUM_ENTRIES` (default 16) entries. Each entry has its own enable bit in a control word. The enable bits run in reverse: entry 0 is controlled by the highest entry bit. A global enable sits above all of them. A separate accept-all mode bypasses the table. The block also raises a one-cycle pulse when a frame runs past `MAX_FRAME` bytes (default 1536).

The header tracker is a three-state machine:
- ST_IDLE waits for the first byte of a frame. Its arcs are: first byte without end-of-frame goes to ST_HDR; a one-byte frame stays in ST_IDLE.
- ST_HDR collects bytes 1 to 5. Its arcs are: end-of-frame goes to ST_IDLE; the sixth byte without end-of-frame goes to ST_BODY.
- ST_BODY counts the payload bytes. End-of-frame returns it to ST_IDLE.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, every table entry, the control word and the accept-all bit are zero. `dec_valid` and `rx_oversize` are low, and a frame with a complete header is dropped.
- R2: A frame is accepted (`dec_accept`=1) when the global enable (control bit `NUM_ENTRIES`) is set and an enabled entry equals all 48 destination bits. `dec_valid` pulses for exactly one cycle, in the cycle after the sixth byte is taken.
- R3: Entry k is enabled by control bit `NUM_ENTRIES-1-k`. An entry that matches but is disabled does not cause acceptance. This holds for the first and the last entry alike.
- R4: With the global enable clear and accept-all off, every frame is dropped, whatever the entry bits are.
- R5: An address that differs from every enabled entry in any single byte (first or last) is dropped.
- R6: With the accept-all bit (bit 4 of register 2·NUM_ENTRIES+1) set, every frame with a full header is accepted regardless of the table. Clearing the bit restores filtering.
- R7: A frame whose end-of-frame flag comes before its sixth byte gets one decision with `dec_accept`=0, in the cycle after its last byte. This holds even with accept-all on.
- R8: Each frame gets exactly one decision. Bytes after the sixth do not produce further decisions. The byte after end-of-frame starts a new frame.
- R9: `rx_oversize` pulses once, in the cycle after byte number `MAX_FRAME+1` of a frame is taken. A frame of exactly `MAX_FRAME` bytes gives no pulse.
- R10: Register 2k holds address bytes 0 and 1 of entry k, with byte 0 in bits 15:8. Register 2k+1 holds bytes 2 to 5, with byte 2 in bits 31:24 and byte 5 in bits 7:0. Byte 0 is the first byte on the wire. Register 2·NUM_ENTRIES is the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index (entries, control word, mode) |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| dec_valid | output | 1 | One-cycle pulse carrying the frame decision |
| dec_accept | output | 1 | Keep (1) or discard (0); zero while dec_valid is low |
| rx_oversize | output | 1 | One-cycle pulse when a frame exceeds MAX_FRAME bytes |

## Verification
The hardest condition to reach from the ports is the oversize pulse at its exact boundary. The stimulus streams one frame of `MAX_FRAME` bytes, which must give no pulse, and then one frame a single byte longer. It records the cycle in which the pulse appears, relative to the byte count.

A second hard case is the reversed enable mapping at the far end of the table. The bench loads the last entry while its enable bit (bit 0) is still clear, shows that a matching frame is dropped, and then sets only that bit. A further check confirms that accept-all cannot rescue a runt frame.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = 8 * MAC_BYTES;
    localparam int PROM_BIT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY
    } hdr_state_e;
endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
    import dafilt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int CFG_AW      = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [CFG_AW-1:0]                   cfg_addr,
    input  logic [31:0]                         cfg_wdata,
    output logic [NUM_ENTRIES-1:0][MAC_W-1:0]   tbl_q,
    output logic [NUM_ENTRIES:0]                ctrl_q,
    output logic                                promisc_q
);
    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(2 * NUM_ENTRIES);
    localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(2 * NUM_ENTRIES + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_ENTRIES; k++) begin
                tbl_q[k] <= '0;
            end
            ctrl_q    <= '0;
            promisc_q <= 1'b0;
        end else if (cfg_we) begin
            for (int k = 0; k < NUM_ENTRIES; k++) begin
                // even register: bytes 0,1 ; odd register: bytes 2..5
                if (cfg_addr == CFG_AW'(2 * k)) begin
                    tbl_q[k][MAC_W-1:32] <= cfg_wdata[15:0];
                end
                if (cfg_addr == CFG_AW'(2 * k + 1)) begin
                    tbl_q[k][31:0] <= cfg_wdata;
                end
            end
            if (cfg_addr == CTRL_ADDR) begin
                ctrl_q <= cfg_wdata[NUM_ENTRIES:0];
            end
            if (cfg_addr == MODE_ADDR) begin
                promisc_q <= cfg_wdata[PROM_BIT];
            end
        end
    end
endmodule

// File: rtl/dafilt_match.sv
module dafilt_match
    import dafilt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES-1:0][MAC_W-1:0] tbl,
    input  logic [NUM_ENTRIES:0]              ctrl_word,
    input  logic [MAC_W-1:0]                  dst,
    output logic                              hit
);
    logic [NUM_ENTRIES-1:0] ent_hit;

    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
        // enable bits run in reverse order of the entries
        assign ent_hit[k] = ctrl_word[NUM_ENTRIES-1-k] && (tbl[k] == dst);
    end

    assign hit = ctrl_word[NUM_ENTRIES] && (|ent_hit);
endmodule

// File: rtl/dafilt_fsm.sv
module dafilt_fsm
    import dafilt_pkg::*;
#(
    parameter int MAX_FRAME = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             hit,
    input  logic             promisc_on,
    output logic [MAC_W-1:0] dst_cand,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             rx_oversize
);
    localparam int              CNT_W    = $clog2(MAX_FRAME + 2);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(MAC_BYTES - 1);
    localparam logic [CNT_W-1:0] OVR_IDX  = CNT_W'(MAX_FRAME);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MAX_FRAME + 1);

    hdr_state_e             st_q, st_d;
    logic [MAC_W-9:0]       hdr_q;
    logic [CNT_W-1:0]       cnt_q;

    assign dst_cand = {hdr_q, rx_data};

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (rx_valid && !rx_last) st_d = ST_HDR;
            ST_HDR: begin
                if (rx_valid) begin
                    if (rx_last)                 st_d = ST_IDLE;
                    else if (cnt_q == HDR_LAST)  st_d = ST_BODY;
                end
            end
            ST_BODY: if (rx_valid && rx_last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q       <= '0;
            cnt_q       <= '0;
            dec_valid   <= 1'b0;
            dec_accept  <= 1'b0;
            rx_oversize <= 1'b0;
        end else begin
            dec_valid   <= 1'b0;
            dec_accept  <= 1'b0;
            rx_oversize <= 1'b0;
            if (rx_valid) begin
                hdr_q <= {hdr_q[MAC_W-17:0], rx_data};
                if (cnt_q == OVR_IDX) begin
                    rx_oversize <= 1'b1;
                end
                if (rx_last) begin
                    cnt_q <= '0;
                end else if (cnt_q != CNT_SAT) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if (st_q == ST_HDR && cnt_q == HDR_LAST) begin
                    dec_valid  <= 1'b1;
                    dec_accept <= promisc_on | hit;
                end else if (rx_last && st_q != ST_BODY) begin
                    dec_valid  <= 1'b1;
                    dec_accept <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import dafilt_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    parameter  int MAX_FRAME   = 1536,
    localparam int CFG_AW      = $clog2(2 * NUM_ENTRIES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              rx_oversize
);
    logic [NUM_ENTRIES-1:0][MAC_W-1:0] tbl;
    logic [NUM_ENTRIES:0]              ctrl_word;
    logic                              promisc_on;
    logic [MAC_W-1:0]                  dst_cand;
    logic                              hit;

    dafilt_regs #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .CFG_AW      (CFG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tbl_q     (tbl),
        .ctrl_q    (ctrl_word),
        .promisc_q (promisc_on)
    );

    dafilt_match #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_match (
        .tbl       (tbl),
        .ctrl_word (ctrl_word),
        .dst       (dst_cand),
        .hit       (hit)
    );

    dafilt_fsm #(
        .MAX_FRAME (MAX_FRAME)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .hit         (hit),
        .promisc_on  (promisc_on),
        .dst_cand    (dst_cand),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept),
        .rx_oversize (rx_oversize)
    );
endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic dec_valid,
    input logic dec_accept,
    input logic rx_oversize,
    input logic promisc_on,
    input logic glb_en
);
    assert_accept_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    assert_decision_follows_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid));

    assert_global_off_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(promisc_on) && !$past(glb_en)) |-> !dec_accept);

    assert_accept_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> ($past(promisc_on) || $past(glb_en)));

    assert_oversize_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_oversize |=> !rx_oversize);

    assert_oversize_on_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_oversize |-> $past(rx_valid));
endmodule

bind dst_addr_filter dafilt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept),
    .rx_oversize (rx_oversize),
    .promisc_on  (promisc_on),
    .glb_en      (ctrl_word[NUM_ENTRIES])
);

// File: tb/tb_dst_addr_filter.sv
module tb_dst_addr_filter;
    localparam int N    = 16;
    localparam int MAXF = 1536;
    localparam int AW   = $clog2(2 * N + 2);

    localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] OWN   = 48'h021A_2B3C_4D5E;
    localparam logic [47:0] LASTD = 48'h021A_2B3C_4D5F;
    localparam logic [47:0] FRSTD = 48'h031A_2B3C_4D5E;
    localparam logic [47:0] MC2   = 48'h0100_5E00_0007;
    localparam logic [47:0] MC15  = 48'h3333_0000_00F1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_last = 1'b0;
    logic          dec_valid, dec_accept, rx_oversize;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int d_cnt, d_at, d_acc, o_cnt, o_at;

    always #2 clk = ~clk;

    dst_addr_filter #(.NUM_ENTRIES(N), .MAX_FRAME(MAXF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .rx_oversize(rx_oversize)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_entry(input int k, input logic [47:0] m);
        wr(2 * k, {16'h0, m[47:32]});
        wr(2 * k + 1, m[31:0]);
    endtask

    task automatic set_ctrl(input logic [N:0] c);
        wr(2 * N, 32'(c));
    endtask

    task automatic set_prom(input bit on);
        wr(2 * N + 1, on ? 32'h10 : 32'h0);
    endtask

    // sample outputs then drive the next byte, each on a falling edge
    task automatic send(input logic [47:0] da, input int len);
        d_cnt = 0; d_at = -1; d_acc = -1; o_cnt = 0; o_at = -1;
        for (int i = 0; i <= len + 1; i++) begin
            @(negedge clk);
            if (dec_valid) begin d_cnt++; d_at = i; d_acc = int'(dec_accept); end
            if (rx_oversize) begin o_cnt++; o_at = i; end
            if (i < len) begin
                rx_valid = 1'b1;
                rx_data  = (i < 6) ? da[47 - 8 * i -: 8] : 8'(i);
                rx_last  = (i == len - 1);
            end else begin
                rx_valid = 1'b0;
                rx_last  = 1'b0;
            end
        end
    endtask

    task automatic expect_dec(input string req, input int acc, input int at);
        chk(req, "decision count", d_cnt, 1);
        chk(req, "decision cycle", d_at, at);
        chk(req, "accept", d_acc, acc);
    endtask

    task automatic t_reset();
        chk("R1", "dec_valid after reset", int'(dec_valid), 0);
        chk("R1", "rx_oversize after reset", int'(rx_oversize), 0);
        send(BC, 8);
        expect_dec("R1", 0, 6);
    endtask

    task automatic t_basic();
        load_entry(0, BC);
        load_entry(1, OWN);
        set_ctrl(17'h1C000);
        send(BC, 10);    expect_dec("R2", 1, 6);
        send(OWN, 6);    expect_dec("R10", 1, 6);
        send(LASTD, 12); expect_dec("R5", 0, 6);
        send(FRSTD, 12); expect_dec("R5", 0, 6);
    endtask

    task automatic t_enable();
        load_entry(2, MC2);
        send(MC2, 8);  expect_dec("R3", 0, 6);
        set_ctrl(17'h1E000);
        send(MC2, 8);  expect_dec("R3", 1, 6);
        load_entry(15, MC15);
        send(MC15, 8); expect_dec("R3", 0, 6);
        set_ctrl(17'h1E001);
        send(MC15, 8); expect_dec("R3", 1, 6);
    endtask

    task automatic t_global();
        set_ctrl(17'h0FFFF);
        send(BC, 8);  expect_dec("R4", 0, 6);
        send(OWN, 8); expect_dec("R4", 0, 6);
        set_ctrl(17'h1E001);
    endtask

    task automatic t_promisc();
        set_ctrl(17'h0);
        set_prom(1'b1);
        send(FRSTD, 9); expect_dec("R6", 1, 6);
        set_prom(1'b0);
        send(FRSTD, 9); expect_dec("R6", 0, 6);
        set_ctrl(17'h1E001);
    endtask

    task automatic t_runt();
        send(BC, 3); expect_dec("R7", 0, 3);
        send(BC, 1); expect_dec("R7", 0, 1);
        set_prom(1'b1);
        send(BC, 5); expect_dec("R7", 0, 5);
        set_prom(1'b0);
    endtask

    task automatic t_long();
        send(BC, 40);  expect_dec("R8", 1, 6);
        send(OWN, 7);  expect_dec("R8", 1, 6);
    endtask

    task automatic t_oversize();
        send(BC, MAXF);
        chk("R9", "pulses at limit", o_cnt, 0);
        send(BC, MAXF + 1);
        chk("R9", "pulses past limit", o_cnt, 1);
        chk("R9", "pulse cycle", o_at, MAXF + 1);
        chk("R9", "decisions in long frame", d_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_enable();
        t_global();
        t_promisc();
        t_runt();
        t_long();
        t_oversize();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule